// File: doc/BRIEF.md
# Packet UART Transmitter with Line-Driver Enable

This block is a serial transmitter that works on whole packets instead of single characters. Packet bytes go into a data queue, and the byte length of each packet goes into a separate length queue. When the length queue holds an entry and the data queue already holds all the bytes for it, the block sends that packet with no pause between its characters. After the last stop bit it keeps the line idle for a programmable number of bit times before the next packet may start.

The block also drives the enable of an external differential line driver. Software can force the enable on. In the automatic mode the block raises the enable a programmable number of bit times before the first start bit and drops it one bit time after the last stop bit. One 32-bit mode word carries the settings and reports the number of queued packets, a busy flag, whether the data queue is non-empty, and a sticky error flag. A synchronous clear input aborts the packet in flight and empties both queues.

Top module: `pkt_uart_tx`

## Requirements
- R1: Each byte is sent as one low start bit, eight data bits least significant bit first, and one high stop bit. Every bit lasts `baud_div`+1 clock cycles. `txd` is high whenever mode bit 7 (busy) is low.
- R2: A nonzero length entry starts a packet only once the data queue holds at least that many bytes. The bytes of one packet follow each other with no gap, so start bits are exactly 10 bit times apart. A length entry of zero is removed and sends nothing.
- R3: The idle hold after a packet's last stop bit is H bit times. H is the gap field (mode bits 15..8), except that H is 1 when the gap field is 0 and automatic enable is on. The next packet's first start bit comes exactly 10+H+L bit times plus one clock after the previous packet's last start bit, where L is the lead field in automatic mode and 0 otherwise.
- R4: While mode bit 6 (manual enable) is set, `txen` is high.
- R5: With mode bit 5 (automatic enable) set, `txen` rises L bit times before a packet's first start bit (L = mode bits 3..0) and falls exactly 11 bit times after that packet's last start bit. It is high during every start or data bit. With bits 5 and 6 both clear, `txen` stays low.
- R6: `mode_rd` holds the following fields, and bits 31..22 read as zero:
  - bit 21: data queue non-empty
  - bits 20..16: number of length entries waiting in the length queue
  - bits 15..8: gap
  - bit 7: busy
  - bit 6: manual enable
  - bit 5: automatic enable
  - bit 4: error
  - bits 3..0: lead
- R7: The error flag (mode bit 4) is set by any of three writes: a length write while the length queue is full, a length write with a value above DATA_DEPTH (that entry is dropped), or a data write while the data queue is full. Once set, it stays set until `clr`.
- R8: The cycle after `clr`, `txd` is high, busy is low, both queues are empty and the error flag is clear. Gap, lead and both enable bits keep their values.
- R9: A write to a full queue is dropped and leaves the queued contents intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous abort and flush of both queues |
| baud_div | input | DIV_W | Bit time minus one, in clock cycles |
| cfg_wr | input | 1 | Load gap, enable and lead fields from `cfg_in` |
| cfg_in | input | 32 | Mode word for a write; bits 15..8, 6, 5 and 3..0 are used |
| data_wr | input | 1 | Push `data_in` into the data queue |
| data_in | input | 8 | Packet byte |
| len_wr | input | 1 | Push `len_in` into the length queue |
| len_in | input | LEN_W | Packet length in bytes |
| mode_rd | output | 32 | Mode and status word |
| txd | output | 1 | Serial line, idle high |
| txen | output | 1 | External line-driver enable |

## Verification
The hardest state to reach from the ports is a full length queue together with a packet that is waiting for its data. The engine drains lengths only after their bytes arrive, so the bench queues lengths while holding back every data byte. This fills the length queue to the brim, forces the overflow error, and shows the engine staying idle while only part of a packet's data is present. Clearing in the middle of a character is reached by waiting a few bit times after a long packet starts. Random rounds mix gap, lead and enable modes, and the bench checks the exact start-bit spacing against the formula in R3.

// File: rtl/pkt_uart_pkg.sv
package pkt_uart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4,
        ST_HOLD  = 3'd5
    } tx_state_e;

    // mode word field positions
    localparam int MB_LEAD_LSB = 0;
    localparam int MB_ERR      = 4;
    localparam int MB_AUTO     = 5;
    localparam int MB_MAN      = 6;
    localparam int MB_BUSY     = 7;
    localparam int MB_GAP_LSB  = 8;
    localparam int MB_PEND_LSB = 16;
    localparam int MB_DATA     = 21;

endpackage

// File: rtl/pkt_uart_fifo.sv
module pkt_uart_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (ptr_q.lvl == LW'(DEPTH));
    assign empty   = (ptr_q.lvl == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem_q[ptr_q.rd];
    assign level   = ptr_q.lvl;

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wr = ptr_q.wr + AW'(1);
            if (do_pop)  ptr_d.rd = ptr_q.rd + AW'(1);
            if (do_push && !do_pop)      ptr_d.lvl = ptr_q.lvl + LW'(1);
            else if (!do_push && do_pop) ptr_d.lvl = ptr_q.lvl - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ptr_q.wr] <= din;
    end

endmodule

// File: rtl/pkt_uart_baud.sv
module pkt_uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q, cnt_d;

    assign tick = run && (cnt_q == div);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pkt_uart_tx.sv
module pkt_uart_tx
    import pkt_uart_pkg::*;
#(
    parameter int DATA_DEPTH = 16,
    parameter int CNT_DEPTH  = 16,
    parameter int DIV_W      = 16,
    localparam int LEN_W     = $clog2(DATA_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_in,
    input  logic             data_wr,
    input  logic [7:0]       data_in,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_in,
    output logic [31:0]      mode_rd,
    output logic             txd,
    output logic             txen
);

    localparam int CLW = $clog2(CNT_DEPTH + 1);

    typedef struct packed {
        tx_state_e        st;
        logic [7:0]       cnt;
        logic [7:0]       sh;
        logic [LEN_W-1:0] left;
        logic             err;
        logic [7:0]       gap;
        logic             man;
        logic             aut;
        logic [3:0]       lead;
    } core_t;

    core_t q, d;

    logic             data_full, data_empty, data_pop;
    logic [LEN_W-1:0] data_level;
    logic [7:0]       data_head;
    logic             len_full, len_empty, len_pop, len_ok;
    logic [CLW-1:0]   len_level;
    logic [LEN_W-1:0] len_head;
    logic             tick, busy, auto_on;
    logic [7:0]       hold_len;
    logic             unused_cfg;

    assign unused_cfg = ^{cfg_in[31:16], cfg_in[7], cfg_in[4]};
    assign len_ok     = (len_in <= LEN_W'(DATA_DEPTH));

    pkt_uart_fifo #(.WIDTH(8), .DEPTH(DATA_DEPTH)) u_data_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr),
        .push  (data_wr),
        .din   (data_in),
        .pop   (data_pop),
        .dout  (data_head),
        .level (data_level),
        .full  (data_full),
        .empty (data_empty)
    );

    pkt_uart_fifo #(.WIDTH(LEN_W), .DEPTH(CNT_DEPTH)) u_len_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr),
        .push  (len_wr && len_ok),
        .din   (len_in),
        .pop   (len_pop),
        .dout  (len_head),
        .level (len_level),
        .full  (len_full),
        .empty (len_empty)
    );

    pkt_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .div   (baud_div),
        .tick  (tick)
    );

    // idle hold after the last stop bit; automatic mode needs at least one bit
    assign hold_len = (q.gap == 8'd0 && q.aut) ? 8'd1 : q.gap;

    always_comb begin
        d        = q;
        data_pop = 1'b0;
        len_pop  = 1'b0;

        if (cfg_wr) begin
            d.gap  = cfg_in[MB_GAP_LSB +: 8];
            d.man  = cfg_in[MB_MAN];
            d.aut  = cfg_in[MB_AUTO];
            d.lead = cfg_in[MB_LEAD_LSB +: 4];
        end

        if ((len_wr && (len_full || !len_ok)) || (data_wr && data_full))
            d.err = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (!len_empty) begin
                    if (len_head == '0) begin
                        len_pop = 1'b1;
                    end else if (data_level >= len_head) begin
                        len_pop = 1'b1;
                        d.left  = len_head;
                        if (q.aut && q.lead != 4'd0) begin
                            d.st  = ST_LEAD;
                            d.cnt = 8'(q.lead);
                        end else begin
                            d.st     = ST_START;
                            data_pop = 1'b1;
                            d.sh     = data_head;
                            d.left   = len_head - LEN_W'(1);
                        end
                    end
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    if (q.cnt == 8'd1) begin
                        d.st     = ST_START;
                        data_pop = 1'b1;
                        d.sh     = data_head;
                        d.left   = q.left - LEN_W'(1);
                    end else begin
                        d.cnt = q.cnt - 8'd1;
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    d.st  = ST_DATA;
                    d.cnt = 8'd0;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    d.sh = {1'b0, q.sh[7:1]};
                    if (q.cnt == 8'd7) d.st = ST_STOP;
                    else               d.cnt = q.cnt + 8'd1;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.left != '0) begin
                        d.st     = ST_START;
                        data_pop = 1'b1;
                        d.sh     = data_head;
                        d.left   = q.left - LEN_W'(1);
                    end else if (hold_len == 8'd0) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st  = ST_HOLD;
                        d.cnt = 8'd0;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if ((q.cnt + 8'd1) >= hold_len) d.st = ST_IDLE;
                    else                            d.cnt = q.cnt + 8'd1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (clr) begin
            d.st   = ST_IDLE;
            d.cnt  = 8'd0;
            d.left = '0;
            d.err  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.st != ST_IDLE);

    always_comb begin
        unique case (q.st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = q.sh[0];
            default:  txd = 1'b1;
        endcase
    end

    assign auto_on = q.aut && ((q.st == ST_LEAD) || (q.st == ST_START) ||
                               (q.st == ST_DATA) || (q.st == ST_STOP) ||
                               (q.st == ST_HOLD && q.cnt == 8'd0));
    assign txen    = q.man || auto_on;

    assign mode_rd = {10'd0, ~data_empty, 5'(len_level), q.gap,
                      busy, q.man, q.aut, q.err, q.lead};

endmodule

// File: rtl/pkt_uart_tx_chk.sv
module pkt_uart_tx_chk #(
    parameter int CNT_DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic [31:0] mode_rd,
    input logic        txd,
    input logic        txen
);

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_rd[7] |-> txd);

    // R4
    man_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd[6] |-> txen);

    // R5
    auto_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd[5] && !txd) |-> txen);

    // R5
    de_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_rd[5] && !mode_rd[6]) |-> !txen);

    // R6
    pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd[20:16] <= 5'(CNT_DEPTH)) && (mode_rd[31:22] == 10'd0));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd[4] && !clr) |=> mode_rd[4]);

    // R8
    clr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mode_rd[21:16] == 6'd0 && !mode_rd[7] && !mode_rd[4] && txd));

endmodule

bind pkt_uart_tx pkt_uart_tx_chk #(.CNT_DEPTH(CNT_DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .mode_rd (mode_rd),
    .txd     (txd),
    .txen    (txen)
);

// File: tb/pkt_uart_tx_bench.sv
module pkt_uart_tx_bench;

    localparam int DD = 16;
    localparam int CD = 16;
    localparam int BD = 5;
    localparam int B  = BD + 1;
    localparam int LW = $clog2(DD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [15:0]   baud_div = 16'(BD);
    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_in = '0;
    logic          data_wr = 1'b0;
    logic [7:0]    data_in = '0;
    logic          len_wr = 1'b0;
    logic [LW-1:0] len_in = '0;
    logic [31:0]   mode_rd;
    logic          txd, txen;

    pkt_uart_tx #(.DATA_DEPTH(DD), .CNT_DEPTH(CD), .DIV_W(16)) u_pkt_uart_tx (
        .clk(clk), .rst_n(rst_n), .clr(clr), .baud_div(baud_div),
        .cfg_wr(cfg_wr), .cfg_in(cfg_in), .data_wr(data_wr), .data_in(data_in),
        .len_wr(len_wr), .len_in(len_in), .mode_rd(mode_rd), .txd(txd), .txen(txen)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    int rx_q[$];
    int st_q[$];
    int en_rise = 0;
    int en_fall = 0;
    bit mon_en = 1'b1;
    bit mon_busy = 1'b0;
    int mon_start = 0;
    logic [7:0] mon_byte;
    logic prev_en = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // line monitor: samples the middle of every bit
    always @(negedge clk) begin
        if (rst_n && txen && !prev_en) en_rise = cyc;
        if (rst_n && !txen && prev_en) en_fall = cyc;
        prev_en = txen;
        if (!mon_en || !rst_n) begin
            mon_busy = 1'b0;
        end else if (!mon_busy) begin
            if (txd == 1'b0) begin
                mon_busy  = 1'b1;
                mon_start = cyc;
                st_q.push_back(cyc);
            end
        end else begin
            int off;
            int k;
            off = cyc - mon_start;
            k   = off / B;
            if (off % B == B / 2 && k >= 1) begin
                if (k <= 8) begin
                    mon_byte[k-1] = txd;
                end else begin
                    chk(txd == 1'b1, "R1 stop bit", int'(txd), 1);
                    rx_q.push_back(int'(mon_byte));
                    mon_busy = 1'b0;
                end
            end
        end
    end

    function automatic int spacing(int gap, bit aut, int lead);
        int h;
        h = (gap == 0 && aut) ? 1 : gap;
        return 10 * B + h * B + 1 + (aut ? lead * B : 0);
    endfunction

    task automatic set_cfg(input int gap, input bit aut, input bit man, input int lead);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_in = {16'd0, 8'(gap), 1'b0, man, aut, 1'b0, 4'(lead)};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push_byte(input int v, input bit keep);
        @(negedge clk);
        data_wr = 1'b1;
        data_in = 8'(v);
        @(negedge clk);
        data_wr = 1'b0;
        if (keep) exp_q.push_back(v & 8'hff);
    endtask

    task automatic push_len(input int n);
        @(negedge clk);
        len_wr = 1'b1;
        len_in = LW'(n);
        @(negedge clk);
        len_wr = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic wait_done();
        while (mode_rd[7] || mode_rd[20:16] != 5'd0) @(negedge clk);
        repeat (2 * B) @(negedge clk);
    endtask

    task automatic check_rx(input string req);
        chk(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
        rx_q.delete();
        exp_q.delete();
    endtask

    task automatic run_tests();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R8: reset state
        chk(mode_rd == 32'd0, "R6 reset mode", int'(mode_rd), 0);
        chk(txd == 1'b1, "R1 reset line", int'(txd), 1);
        chk(txen == 1'b0, "R5 reset enable", int'(txen), 0);

        // R6: readback of written fields
        set_cfg(3, 1'b0, 1'b0, 2);
        chk(mode_rd == 32'h0000_0302, "R6 cfg readback", int'(mode_rd), 32'h302);

        // R6 R1: pending count and busy around a packet start
        st_q.delete();
        push_byte(8'hA5, 1'b1);
        push_byte(8'h3C, 1'b1);
        push_byte(8'h01, 1'b1);
        chk(mode_rd[21] == 1'b1, "R6 data nonempty", int'(mode_rd[21]), 1);
        push_len(3);
        chk(mode_rd[20:16] == 5'd1, "R6 pending one", int'(mode_rd[20:16]), 1);
        chk(mode_rd[7] == 1'b0, "R6 not busy yet", int'(mode_rd[7]), 0);
        @(negedge clk);
        chk(mode_rd[7] == 1'b1, "R6 busy", int'(mode_rd[7]), 1);
        chk(mode_rd[20:16] == 5'd0, "R6 pending taken", int'(mode_rd[20:16]), 0);
        wait_done();
        check_rx("R1");

        // R2 R3: back-to-back bytes, gap between packets, no enable
        st_q.delete();
        push_byte(8'h11, 1'b1);
        push_byte(8'h80, 1'b1);
        push_byte(8'hFE, 1'b1);
        push_len(2);
        push_len(1);
        wait_done();
        check_rx("R2");
        if (st_q.size() == 3) begin
            chk(st_q[1] - st_q[0] == 10 * B, "R2 byte spacing", st_q[1] - st_q[0], 10 * B);
            chk(st_q[2] - st_q[1] == spacing(3, 1'b0, 2), "R3 gap spacing",
                st_q[2] - st_q[1], spacing(3, 1'b0, 2));
        end else chk(1'b0, "R3 start count", st_q.size(), 3);

        // R4: manual enable
        set_cfg(3, 1'b0, 1'b1, 0);
        chk(txen == 1'b1, "R4 manual on", int'(txen), 1);
        set_cfg(3, 1'b0, 1'b0, 0);
        chk(txen == 1'b0, "R4 manual off", int'(txen), 0);

        // R5: automatic enable, lead 3, gap 2
        set_cfg(2, 1'b1, 1'b0, 3);
        chk(txen == 1'b0, "R5 auto idle low", int'(txen), 0);
        st_q.delete();
        push_byte(8'h5A, 1'b1);
        push_byte(8'hC3, 1'b1);
        push_len(2);
        wait_done();
        check_rx("R5");
        if (st_q.size() == 2) begin
            chk(st_q[0] - en_rise == 3 * B, "R5 lead", st_q[0] - en_rise, 3 * B);
            chk(en_fall - st_q[1] == 11 * B, "R5 release", en_fall - st_q[1], 11 * B);
        end else chk(1'b0, "R5 start count", st_q.size(), 2);
        chk(txen == 1'b0, "R5 low after", int'(txen), 0);

        // R3: automatic with zero gap holds one bit
        set_cfg(0, 1'b1, 1'b0, 1);
        st_q.delete();
        push_byte(8'h77, 1'b1);
        push_byte(8'h08, 1'b1);
        push_len(1);
        push_len(1);
        wait_done();
        check_rx("R3");
        if (st_q.size() == 2)
            chk(st_q[1] - st_q[0] == spacing(0, 1'b1, 1), "R3 auto zero gap",
                st_q[1] - st_q[0], spacing(0, 1'b1, 1));
        else chk(1'b0, "R3 start count", st_q.size(), 2);

        // R2: zero length discarded; packet waits for full data
        set_cfg(1, 1'b0, 1'b0, 0);
        push_len(0);
        @(negedge clk);
        chk(mode_rd[20:16] == 5'd0 && !mode_rd[7], "R2 zero length",
            int'(mode_rd[20:16]), 0);
        push_byte(8'h42, 1'b1);
        push_len(2);
        repeat (4 * B) @(negedge clk);
        chk(mode_rd[7] == 1'b0 && txd == 1'b1, "R2 waits for data", int'(mode_rd[7]), 0);
        chk(mode_rd[20:16] == 5'd1, "R2 still pending", int'(mode_rd[20:16]), 1);
        push_byte(8'h99, 1'b1);
        wait_done();
        check_rx("R2");

        // R7 R9: length queue overflow with no data present
        for (int i = 0; i < CD; i++) push_len(1);
        chk(mode_rd[4] == 1'b0, "R7 no error when full", int'(mode_rd[4]), 0);
        push_len(1);
        chk(mode_rd[4] == 1'b1, "R7 len overflow", int'(mode_rd[4]), 1);
        chk(mode_rd[20:16] == 5'(CD), "R9 len kept", int'(mode_rd[20:16]), CD);
        set_cfg(5, 1'b0, 1'b0, 0);
        chk(mode_rd[4] == 1'b1, "R7 sticky", int'(mode_rd[4]), 1);
        do_clr();
        chk(mode_rd == 32'h0000_0500, "R8 clr mode", int'(mode_rd), 32'h500);

        // R7: oversize length dropped
        push_len(DD + 1);
        chk(mode_rd[4] == 1'b1, "R7 oversize", int'(mode_rd[4]), 1);
        chk(mode_rd[20:16] == 5'd0, "R7 oversize dropped", int'(mode_rd[20:16]), 0);
        do_clr();

        // R9 R7: data queue overflow keeps first bytes
        set_cfg(0, 1'b0, 1'b0, 0);
        for (int i = 0; i < DD; i++) push_byte(i * 13 + 1, 1'b1);
        push_byte(8'hEE, 1'b0);
        chk(mode_rd[4] == 1'b1, "R7 data overflow", int'(mode_rd[4]), 1);
        push_len(DD);
        wait_done();
        check_rx("R9");
        do_clr();

        // R8: clear in the middle of a character
        mon_en = 1'b0;
        for (int i = 0; i < 8; i++) push_byte(8'h00, 1'b0);
        push_len(8);
        repeat (3 * B) @(negedge clk);
        do_clr();
        chk(txd == 1'b1, "R8 line idle", int'(txd), 1);
        chk(mode_rd[7] == 1'b0, "R8 not busy", int'(mode_rd[7]), 0);
        chk(mode_rd[21:16] == 6'd0, "R8 queues empty", int'(mode_rd[21:16]), 0);
        repeat (12 * B) @(negedge clk);
        chk(txd == 1'b1, "R8 stays idle", int'(txd), 1);
        rx_q.delete();
        mon_en = 1'b1;

        // R2 R3 R5: random rounds
        for (int r = 0; r < 6; r++) begin
            int gap;
            int lead;
            bit aut;
            int npk;
            int lens[3];
            gap  = $urandom % 4;
            aut  = 1'($urandom % 2);
            lead = $urandom % 4;
            npk  = 2 + $urandom % 2;
            set_cfg(gap, aut, 1'b0, lead);
            st_q.delete();
            for (int p = 0; p < npk; p++) begin
                lens[p] = 1 + $urandom % 5;
                for (int j = 0; j < lens[p]; j++) push_byte($urandom % 256, 1'b1);
                push_len(lens[p]);
            end
            wait_done();
            check_rx("R2 random");
            if (st_q.size() >= lens[0] + 1)
                chk(st_q[lens[0]] - st_q[lens[0] - 1] == spacing(gap, aut, lead), "R3 random gap",
                    st_q[lens[0]] - st_q[lens[0] - 1], spacing(gap, aut, lead));
            chk(txen == 1'b0, "R5 random release", int'(txen), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "WATCHDOG", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule